// File: doc/BRIEF.md
# Pairwise Comparison Response Generator

This block turns a fixed set of twenty unsigned voltage readings into a 190-bit binary response. Ten of the readings come from pull-up settings and ten from pull-down settings. A start pulse opens a loading window. The readings then arrive on a valid/ready stream, at most one per clock, and are stored in arrival order. Once the last reading is stored, the block walks through every unordered pair of stored readings. It uses one magnitude comparator and produces one response bit per clock.

The response does not depend on any external challenge. The same set of readings always fills the same bit positions. A one-cycle done pulse marks the finished vector. The vector then stays constant until the next start. Analog capture, error correction and hashing are handled by neighbouring blocks.

Top module: `pairwise_response_gen`

## Requirements
- R1: After synchronous reset, `smp_ready_o`, `busy_o` and `done_o` are 0 and `resp_o` is all zeros.
- R2: A start pulse given while idle raises `busy_o` and `smp_ready_o` on the next cycle.
- R3: A reading is accepted on each cycle where `smp_valid_i` and `smp_ready_o` are both high and `start_i` is low. The first accepted reading becomes sample index 0 and the twentieth becomes index 19.
- R4: Bit k of `resp_o` belongs to the pair (i, j) with i < j. Pairs are counted with i as the outer loop (0..18) and j as the inner loop (i+1..19). Bit 0 is the pair (0,1) and bit 189 is the pair (18,19).
- R5: A response bit is 1 only when sample i is strictly below sample j. Equal readings give 0.
- R6: While pairs are being compared, `smp_ready_o` is low, and readings offered on the stream do not change the response.
- R7: `done_o` goes high for exactly one cycle, at the 190th rising edge after the edge that accepted the twentieth reading.
- R8: After done, `resp_o` stays unchanged until the next start. A start clears `resp_o` to zero.
- R9: A start pulse given during the comparison phase is ignored, and the run finishes with its normal timing and result.
- R10: A start pulse given during loading discards the readings stored so far. The next accepted reading becomes index 0.
- R11: Idle cycles (valid low) between readings only delay loading and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new loading window |
| smp_valid_i | input | 1 | Reading valid |
| smp_data_i | input | 16 | Unsigned ADC reading |
| smp_ready_o | output | 1 | Block can take a reading |
| busy_o | output | 1 | Loading or comparing |
| done_o | output | 1 | One-cycle pulse when the response is complete |
| resp_o | output | 190 | Packed pairwise response |

## Verification
On every cycle, the assertions check the following:
- back-pressure during the comparison phase;
- the single-cycle done pulse and its link to the final pair step;
- the ordering of the pair indices;
- that the response stays frozen while idle;
- that a comparison run, once started, cannot be stopped.

Some behaviour only the bench scenarios can show. These are the actual bit values and their positions, the exact 190-cycle latency, the discard of partial loads on restart, and the fact that gaps and ignored readings leave the result unchanged. The bench checks these against a response it computes itself from the readings it drives.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CMP  = 2'd2
  } pcr_state_t;

  // number of unordered pairs from n items
  function automatic int unsigned pair_count(input int unsigned n);
    return (n * (n - 1)) / 2;
  endfunction

  // width needed to index n items (at least 1)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pcr_sample_store.sv
module pcr_sample_store #(
  parameter int unsigned N_SMP = 20,
  parameter int unsigned SMP_W = 16,
  parameter int unsigned IW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [SMP_W-1:0] wr_data,
  input  logic [IW-1:0]    rd_idx_a,
  input  logic [IW-1:0]    rd_idx_b,
  output logic [SMP_W-1:0] rd_a,
  output logic [SMP_W-1:0] rd_b
);

  logic [SMP_W-1:0] mem [N_SMP];

  for (genvar g = 0; g < N_SMP; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= '0;
      else if (wr_en && (wr_idx == IW'(g)))
        mem[g] <= wr_data;
    end
  end

  assign rd_a = mem[rd_idx_a];
  assign rd_b = mem[rd_idx_b];

endmodule

// File: rtl/pcr_pair_seq.sv
module pcr_pair_seq #(
  parameter int unsigned N_SMP  = 20,
  parameter int unsigned IW     = 5,
  parameter int unsigned RESP_W = 190,
  parameter int unsigned KW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [IW-1:0] idx_i,
  output logic [IW-1:0] idx_j,
  output logic [KW-1:0] bit_k,
  output logic          last
);

  localparam logic [IW-1:0] J_TOP  = IW'(N_SMP - 1);
  localparam logic [KW-1:0] K_LAST = KW'(RESP_W - 1);

  logic row_end;
  assign row_end = (idx_j == J_TOP);
  assign last    = (bit_k == K_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_i <= '0;
      idx_j <= IW'(1);
      bit_k <= '0;
    end else if (step && !last) begin
      bit_k <= bit_k + KW'(1);
      if (row_end) begin
        idx_i <= idx_i + IW'(1);
        idx_j <= idx_i + IW'(2);
      end else begin
        idx_j <= idx_j + IW'(1);
      end
    end
  end

endmodule

// File: rtl/pcr_resp_pack.sv
module pcr_resp_pack #(
  parameter int unsigned RESP_W = 190,
  parameter int unsigned KW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [KW-1:0]     wr_idx,
  input  logic              wr_bit,
  output logic [RESP_W-1:0] resp
);

  for (genvar g = 0; g < RESP_W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear)
        resp[g] <= 1'b0;
      else if (wr_en && (wr_idx == KW'(g)))
        resp[g] <= wr_bit;
    end
  end

endmodule

// File: rtl/pairwise_response_gen.sv
module pairwise_response_gen
  import pcr_pkg::*;
#(
  parameter int unsigned N_SMP = 20,
  parameter int unsigned SMP_W = 16,
  localparam int unsigned RESP_W = pair_count(N_SMP),
  localparam int unsigned IW     = idx_width(N_SMP),
  localparam int unsigned KW     = idx_width(RESP_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  output logic              smp_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RESP_W-1:0] resp_o
);

  localparam logic [IW-1:0] LD_LAST = IW'(N_SMP - 1);

  pcr_state_t       state;
  logic [IW-1:0]    ld_cnt;
  logic             done_q;

  // named internal events
  logic             start_go;
  logic             accept;
  logic             load_last;
  logic             cmp_active;
  logic             seq_last;
  logic [IW-1:0]    pair_i;
  logic [IW-1:0]    pair_j;
  logic [KW-1:0]    pair_k;
  logic [SMP_W-1:0] val_i;
  logic [SMP_W-1:0] val_j;
  logic             cmp_bit;

  assign cmp_active  = (state == ST_CMP);
  assign smp_ready_o = (state == ST_LOAD);
  assign busy_o      = (state != ST_IDLE);
  assign start_go    = start_i && !cmp_active;
  assign accept      = smp_valid_i && smp_ready_o && !start_i;
  assign load_last   = accept && (ld_cnt == LD_LAST);
  assign cmp_bit     = (val_i < val_j);
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ld_cnt <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= cmp_active && seq_last;
      if (start_go) begin
        state  <= ST_LOAD;
        ld_cnt <= '0;
      end else begin
        unique case (state)
          ST_LOAD: begin
            if (accept) begin
              ld_cnt <= ld_cnt + IW'(1);
              if (load_last) state <= ST_CMP;
            end
          end
          ST_CMP:  if (seq_last) state <= ST_IDLE;
          default: state <= state;
        endcase
      end
    end
  end

  pcr_sample_store #(.N_SMP(N_SMP), .SMP_W(SMP_W), .IW(IW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept),
    .wr_idx   (ld_cnt),
    .wr_data  (smp_data_i),
    .rd_idx_a (pair_i),
    .rd_idx_b (pair_j),
    .rd_a     (val_i),
    .rd_b     (val_j)
  );

  pcr_pair_seq #(.N_SMP(N_SMP), .IW(IW), .RESP_W(RESP_W), .KW(KW)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .clear (start_go),
    .step  (cmp_active),
    .idx_i (pair_i),
    .idx_j (pair_j),
    .bit_k (pair_k),
    .last  (seq_last)
  );

  pcr_resp_pack #(.RESP_W(RESP_W), .KW(KW)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clear  (start_go),
    .wr_en  (cmp_active),
    .wr_idx (pair_k),
    .wr_bit (cmp_bit),
    .resp   (resp_o)
  );

endmodule

// File: rtl/pairwise_response_gen_chk.sv
module pairwise_response_gen_chk #(
  parameter int unsigned N_SMP  = 20,
  parameter int unsigned RESP_W = 190,
  parameter int unsigned IW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              smp_ready_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [RESP_W-1:0] resp_o,
  input logic              cmp_active,
  input logic              seq_last,
  input logic [IW-1:0]     pair_i,
  input logic [IW-1:0]     pair_j
);

  assert_ready_busy_R2: assert property (@(posedge clk) disable iff (rst)
    smp_ready_o |-> busy_o);

  assert_pair_order_R4: assert property (@(posedge clk) disable iff (rst)
    cmp_active |-> ((pair_i < pair_j) && (pair_j <= IW'(N_SMP - 1))));

  assert_no_ready_cmp_R6: assert property (@(posedge clk) disable iff (rst)
    cmp_active |-> !smp_ready_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_active && seq_last) |=> (done_o && !busy_o));

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(resp_o));

  assert_cmp_runs_on_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_active && !seq_last) |=> cmp_active);

endmodule

bind pairwise_response_gen pairwise_response_gen_chk #(
  .N_SMP(N_SMP), .RESP_W(RESP_W), .IW(IW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .smp_ready_o (smp_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .resp_o      (resp_o),
  .cmp_active  (cmp_active),
  .seq_last    (seq_last),
  .pair_i      (pair_i),
  .pair_j      (pair_j)
);

// File: tb/pairwise_response_gen_bench.sv
module pairwise_response_gen_bench;

  localparam int NS = 20;
  localparam int RW = 190;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          smp_valid_i = 1'b0;
  logic [15:0]   smp_data_i = '0;
  logic          smp_ready_o;
  logic          busy_o;
  logic          done_o;
  logic [RW-1:0] resp_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] smp [NS];

  always #10 clk = ~clk;

  pairwise_response_gen u_pairwise_response_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .smp_ready_o(smp_ready_o), .busy_o(busy_o),
    .done_o(done_o), .resp_o(resp_o)
  );

  task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected response: outer i, inner j, bit set when smp[i] < smp[j]
  function automatic logic [RW-1:0] expect_resp();
    logic [RW-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < NS - 1; i++)
      for (int j = i + 1; j < NS; j++) begin
        r[k] = (smp[i] < smp[j]);
        k++;
      end
    return r;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // feed all samples; on return the time is the negedge after the last accept edge
  task automatic feed(input bit gaps);
    int n = 0;
    while (n < NS) begin
      logic acc;
      if (gaps && (n % 3 == 1)) begin
        smp_valid_i = 1'b0;
        @(posedge clk); @(negedge clk);
      end
      smp_valid_i = 1'b1;
      smp_data_i  = smp[n];
      acc = smp_ready_o;
      @(posedge clk); @(negedge clk);
      if (acc) n++;
    end
    smp_valid_i = 1'b0;
  endtask

  // wait for done; junk keeps valid high, mid_start pulses start mid-compare
  task automatic wait_done(input bit junk, input bit mid_start, output int lat);
    lat = 0;
    smp_valid_i = junk;
    smp_data_i  = 16'hFFFF;
    while (!done_o && lat < 400) begin
      start_i = mid_start && (lat == 50);
      if (lat == 60) chk("R6 ready low while comparing", RW'(smp_ready_o), RW'(0));
      @(posedge clk); @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    smp_valid_i = 1'b0;
  endtask

  task automatic run(input string tag, input bit gaps, input bit junk, input bit mid_start);
    int lat;
    pulse_start();
    chk({tag, " R2 ready after start"}, RW'({smp_ready_o, busy_o}), RW'(2'b11));
    feed(gaps);
    wait_done(junk, mid_start, lat);
    chk({tag, " R7 done latency"}, RW'(lat), RW'(190));
    chk({tag, " R4 R5 response"}, resp_o, expect_resp());
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, RW'(done_o), RW'(0));
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", RW'({smp_ready_o, busy_o, done_o}), RW'(0));
    chk("R1 reset response", resp_o, '0);
  endtask

  task automatic t_ascending();
    for (int i = 0; i < NS; i++) smp[i] = 16'(100 + i * 7);
    run("ascending", 1'b0, 1'b0, 1'b0);
    chk("R5 all ones ascending", resp_o, {RW{1'b1}});
  endtask

  task automatic t_descending();
    for (int i = 0; i < NS; i++) smp[i] = 16'(60000 - i * 11);
    run("descending", 1'b0, 1'b0, 1'b0);
    chk("R5 all zeros descending", resp_o, '0);
  endtask

  task automatic t_equal();
    for (int i = 0; i < NS; i++) smp[i] = 16'h4000;
    run("equal", 1'b0, 1'b0, 1'b0);
    chk("R5 equal gives zero", resp_o, '0);
  endtask

  task automatic t_mixed_gaps();
    logic [31:0] s = 32'h1234_5678;
    for (int i = 0; i < NS; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      smp[i] = s[31:16];
    end
    smp[0] = 16'd5; smp[1] = 16'd9; smp[18] = 16'd700; smp[19] = 16'd300;
    run("mixed R3 R11", 1'b1, 1'b0, 1'b0);
    chk("R4 bit0 pair(0,1)", RW'(resp_o[0]), RW'(1));
    chk("R4 bit189 pair(18,19)", RW'(resp_o[189]), RW'(0));
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < NS; i++) smp[i] = 16'((i * 37) % 23 * 1000);
    run("junk R6", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_start_in_cmp();
    for (int i = 0; i < NS; i++) smp[i] = 16'((i % 5) * 300 + (i % 3));
    run("midstart R9", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_hold_and_clear();
    logic [RW-1:0] snap = resp_o;
    for (int c = 0; c < 6; c++) begin
      smp_valid_i = c[0]; smp_data_i = 16'h0001;
      @(negedge clk);
    end
    smp_valid_i = 1'b0;
    chk("R8 response held after done", resp_o, snap);
    pulse_start();
    chk("R8 start clears response", resp_o, '0);
    // abandon this load by restarting mid-way (R10)
    for (int i = 0; i < 7; i++) begin
      smp_valid_i = 1'b1; smp_data_i = 16'hFFF0 - 16'(i);
      @(negedge clk);
    end
    smp_valid_i = 1'b0;
    for (int i = 0; i < NS; i++) smp[i] = 16'(i[0] ? 16'd50 + i : 16'd900 - i);
    run("restart R10", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_ascending();
    t_descending();
    t_equal();
    t_mixed_gaps();
    t_backpressure();
    t_start_in_cmp();
    t_hold_and_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule